// File: doc/BRIEF.md
# Vectored Interrupt Source Controller

The controller gathers twelve interrupt sources and offers the processor one request level. That level is the highest among sources that are pending, enabled and given a nonzero level. Ten sources are hardware lines, and a rising edge on a line latches that source's pending flag. The last two sources are software sources: writes through a set strobe raise them. Each source owns an 8-bit control register that holds its pending flag, an enable bit and a 3-bit level. A write with the pending bit at 1 clears the flag. A shared general register holds the global enable, and an 8-bit base register sets where the vector range starts.

When the processor pulses the acknowledge strobe, the controller captures a vector equal to the base plus the winning source's fixed index. The source at index 2 is the abort source. Its register also shows the live state of the abort switch, separate from its latched pending flag. With the base left at its reset value 0x40, the vectors run from 0x40 to 0x4B.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every source is cleared (pending 0, enable 0, level 0), the global enable is 0, the base register holds 0x40, irq_level is 0, vec_valid is 0 and vec_out is 0x00.
- R2: For a hardware source (index 0 to 9), the pending flag (register bit 7) is set at the clock edge where its hw_req line is first sampled high after being low. A line that stays high does not set the flag again once it has been cleared.
- R3: A reg_wr to source address i (0 to 11) stores bit 3 as the enable and bits 2:0 as the level. A written bit 7 of 1 clears the pending flag, and a written bit 7 of 0 leaves it unchanged. If a set event arrives on the same edge, the set wins.
- R4: A read of source address i returns pending in bit 7, enable in bit 3, level in bits 2:0, and 0 in bits 5:4. Bit 6 shows the live abort_sw input for index 2 and reads 0 for every other source. Addresses 14 and 15 read 0.
- R5: The software sources (index 10 and 11) ignore hw_req. Their pending flag is set only when reg_set is asserted with their address and reg_wdata bit 7 at 1. A plain reg_wr never sets it.
- R6: Address 12 is the general register. Bit 4 is the global enable, and the register reads back only that bit. While the global enable is 0, irq_level is 0.
- R7: irq_level is the maximum level among sources that are pending, enabled and at a nonzero level. It follows the register state with no added delay.
- R8: When several active sources share the maximum level, the one with the lowest index wins.
- R9: Address 13 is the 8-bit base register, readable and writable. The edge that samples iack high captures vec_out = (base + winner index) mod 256 and raises vec_valid for exactly one cycle. vec_out holds its value until the next acknowledge.
- R10: An acknowledge with no winner (nothing active, or the global enable is 0) captures vec_out = 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | 12 | Source request lines; bits 10 and 11 are ignored |
| abort_sw | input | 1 | Live abort switch state |
| reg_wr | input | 1 | Register write strobe |
| reg_set | input | 1 | Software-source set strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| iack | input | 1 | Interrupt acknowledge strobe |
| irq_level | output | 3 | Requested interrupt level |
| vec_out | output | 8 | Vector captured on acknowledge |
| vec_valid | output | 1 | One-cycle pulse after an acknowledge |

## Verification
The assertions check every cycle that the winner is active, at the maximum level and at the lowest index on a tie. They also check that the level is zero while globally disabled, that an edge sets pending, that a clearing write clears it, that software sources ignore their lines, and that every acknowledge gives a one-cycle valid pulse with 0xFF when nothing wins. The vector arithmetic, including wrap past 0xFF, the read-back format with the live abort bit, and the no-retrigger behaviour of a line held high are shown only by the bench. The bench does this through a per-source level sweep and a long pseudo-random register sequence compared against its own model.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int LVL_W      = 3;
  localparam int DATA_W     = 8;
  localparam int PEND_BIT   = 7;
  localparam int LIVE_BIT   = 6;
  localparam int GEN_EN_BIT = 4;
  localparam int EN_BIT     = 3;
  localparam logic [DATA_W-1:0] SPURIOUS_VEC = 8'hFF;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic pend;
    logic en;
    lvl_t lvl;
  } src_ctl_t;

  // A source competes when it is pending, enabled and at a nonzero level.
  function automatic logic is_active(input src_ctl_t c);
    return c.pend && c.en && (c.lvl != '0);
  endfunction

  // Read-back layout of a per-source control register.
  function automatic logic [DATA_W-1:0] pack_ctl(input src_ctl_t c, input logic live);
    logic [DATA_W-1:0] r;
    r              = '0;
    r[PEND_BIT]    = c.pend;
    r[LIVE_BIT]    = live;
    r[EN_BIT]      = c.en;
    r[LVL_W-1:0]   = c.lvl;
    return r;
  endfunction

  // Vector arithmetic: base plus fixed index, wrapping at the data width.
  function automatic logic [DATA_W-1:0] vec_of(input logic [DATA_W-1:0] base, input int unsigned idx);
    return base + DATA_W'(idx);
  endfunction
endpackage

// File: rtl/ivc_src_reg.sv
module ivc_src_reg
  import ivc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int MY_ADDR  = 0,
  parameter bit IS_SW    = 1'b0,
  parameter bit HAS_LIVE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_in,
  input  logic              live_in,
  input  logic              wr_stb,
  input  logic              set_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wd_pend,
  input  logic              wd_en,
  input  lvl_t              wd_lvl,
  output lvl_t              lvl_o,
  output logic [DATA_W-1:0] rd_val,
  output logic              active
);
  src_ctl_t ctl;
  logic     req_q;
  logic     req_rise;
  logic     hit;
  logic     set_ev;
  logic     clr_ev;

  assign hit      = (addr == ADDR_W'(MY_ADDR));
  assign req_rise = req_in & ~req_q;
  // Software sources are raised only by the set strobe; hardware sources by an edge.
  assign set_ev   = IS_SW ? (set_stb & hit & wd_pend) : req_rise;
  assign clr_ev   = wr_stb & hit & wd_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      ctl   <= '0;
    end else begin
      req_q <= req_in;
      if (wr_stb && hit) begin
        ctl.en  <= wd_en;
        ctl.lvl <= wd_lvl;
      end
      if (set_ev)      ctl.pend <= 1'b1;
      else if (clr_ev) ctl.pend <= 1'b0;
    end
  end

  assign rd_val = pack_ctl(ctl, HAS_LIVE ? live_in : 1'b0);
  assign active = is_active(ctl);
  assign lvl_o  = ctl.lvl;

  assert_hw_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_SW && $rose(req_in)) |=> ctl.pend);

  assert_sw_ignores_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_SW && !set_stb && !ctl.pend) |=> !ctl.pend);

  assert_clear_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && hit && wd_pend && !set_ev) |=> !ctl.pend);

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && hit) |=> ($stable(ctl.en) && $stable(ctl.lvl)));
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] active,
  input  lvl_t               lvls [NUM_SRC],
  input  logic               glb_en,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output lvl_t               win_lvl
);
  // Scan from the top index down with >= so the lowest index keeps a tie.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (glb_en && active[i] && (lvls[i] >= win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = lvls[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    assert_win_is_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_en && active[g]) |-> (win_valid && (win_lvl >= lvls[g])));
    assert_tie_low_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && active[g] && (lvls[g] == win_lvl)) |-> (win_idx <= IDX_W'(g)));
  end

  assert_win_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> active[win_idx]);

  assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !win_valid);
endmodule

// File: rtl/ivc_vec.sv
module ivc_vec
  import ivc_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iack,
  input  logic [DATA_W-1:0] base,
  input  logic              win_valid,
  input  logic [IDX_W-1:0]  win_idx,
  output logic [DATA_W-1:0] vec_out,
  output logic              vec_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= iack;
      if (iack) vec_out <= win_valid ? vec_of(base, win_idx) : SPURIOUS_VEC;
    end
  end

  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    iack |=> vec_valid);

  assert_no_ack_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !iack |=> (!vec_valid && $stable(vec_out)));

  assert_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && !win_valid) |=> (vec_out == SPURIOUS_VEC));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int               NUM_SRC   = 12,
  parameter int               SW_FIRST  = 10,
  parameter int               ABORT_IDX = 2,
  parameter int               ADDR_W    = 4,
  parameter int               GEN_ADDR  = 12,
  parameter int               BASE_ADDR = 13,
  parameter logic [7:0]       BASE_RST  = 8'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hw_req,
  input  logic               abort_sw,
  input  logic               reg_wr,
  input  logic               reg_set,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               iack,
  output logic [2:0]         irq_level,
  output logic [7:0]         vec_out,
  output logic               vec_valid
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] src_active;
  lvl_t               src_lvl [NUM_SRC];
  logic [DATA_W-1:0]  src_rd  [NUM_SRC];
  logic               glb_en;
  logic [DATA_W-1:0]  vec_base;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  lvl_t               win_lvl;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    ivc_src_reg #(
      .ADDR_W   (ADDR_W),
      .MY_ADDR  (g),
      .IS_SW    (g >= SW_FIRST),
      .HAS_LIVE (g == ABORT_IDX)
    ) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_in  (hw_req[g]),
      .live_in (abort_sw),
      .wr_stb  (reg_wr),
      .set_stb (reg_set),
      .addr    (reg_addr),
      .wd_pend (reg_wdata[PEND_BIT]),
      .wd_en   (reg_wdata[EN_BIT]),
      .wd_lvl  (reg_wdata[LVL_W-1:0]),
      .lvl_o   (src_lvl[g]),
      .rd_val  (src_rd[g]),
      .active  (src_active[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en   <= 1'b0;
      vec_base <= BASE_RST;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_W'(GEN_ADDR))  glb_en   <= reg_wdata[GEN_EN_BIT];
      if (reg_addr == ADDR_W'(BASE_ADDR)) vec_base <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reg_addr == ADDR_W'(i)) reg_rdata = src_rd[i];
    end
    if (reg_addr == ADDR_W'(GEN_ADDR)) reg_rdata[GEN_EN_BIT] = glb_en;
    if (reg_addr == ADDR_W'(BASE_ADDR)) reg_rdata = vec_base;
  end

  ivc_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (src_active),
    .lvls      (src_lvl),
    .glb_en    (glb_en),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  assign irq_level = win_lvl;

  ivc_vec #(.IDX_W(IDX_W)) u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .iack      (iack),
    .base      (vec_base),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .vec_out   (vec_out),
    .vec_valid (vec_valid)
  );

  assert_level_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> glb_en);

  assert_level_from_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> (src_active != '0));
endmodule

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] hw_req;
  logic        abort_sw;
  logic        reg_wr, reg_set;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        iack;
  logic [2:0]  irq_level;
  logic [7:0]  vec_out;
  logic        vec_valid;

  int n_chk = 0;
  int n_err = 0;

  bit m_pend [12];
  bit m_en   [12];
  int m_lvl  [12];
  bit m_gen;
  int m_base;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .abort_sw(abort_sw),
    .reg_wr(reg_wr), .reg_set(reg_set), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .iack(iack), .irq_level(irq_level),
    .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    logic [7:0] r = 8'h00;
    if (a < 12) begin
      r[7]   = m_pend[a];
      r[6]   = (a == 2) ? abort_sw : 1'b0;
      r[3]   = m_en[a];
      r[2:0] = 3'(m_lvl[a]);
    end else if (a == 12) begin
      r[4] = m_gen;
    end else if (a == 13) begin
      r = 8'(m_base);
    end
    return r;
  endfunction

  // Bench-side arbitration: ascending scan, strictly greater replaces.
  task automatic expect_win(output logic [2:0] el, output logic [7:0] ev);
    int best = 0;
    int bi = -1;
    for (int i = 0; i < 12; i++) begin
      if (m_pend[i] && m_en[i] && m_lvl[i] != 0 && m_lvl[i] > best) begin
        best = m_lvl[i];
        bi = i;
      end
    end
    if (!m_gen || bi < 0) begin
      el = 3'd0;
      ev = 8'hFF;
    end else begin
      el = 3'(best);
      ev = 8'((m_base + bi) % 256);
    end
  endtask

  task automatic wr_reg(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a < 12) begin
      m_en[a] = d[3];
      m_lvl[a] = int'(d[2:0]);
      if (d[7]) m_pend[a] = 1'b0;
    end else if (a == 12) begin
      m_gen = d[4];
    end else if (a == 13) begin
      m_base = int'(d);
    end
  endtask

  task automatic set_sw(input int a);
    @(negedge clk);
    reg_set = 1'b1; reg_addr = 4'(a); reg_wdata = 8'h80;
    @(negedge clk);
    reg_set = 1'b0;
    if (a >= 10 && a < 12) m_pend[a] = 1'b1;
  endtask

  task automatic pulse(input int i);
    @(negedge clk);
    hw_req[i] = 1'b1;
    @(negedge clk);
    hw_req[i] = 1'b0;
    if (i < 10) m_pend[i] = 1'b1;
  endtask

  task automatic rd_chk(input string tag, input int a);
    reg_addr = 4'(a);
    #1;
    chk(tag, {24'd0, reg_rdata}, {24'd0, exp_rd(a)});
  endtask

  task automatic ack_chk(input string tag);
    logic [2:0] el;
    logic [7:0] ev;
    expect_win(el, ev);
    chk({tag, " R7 level"}, {29'd0, irq_level}, {29'd0, el});
    @(negedge clk);
    iack = 1'b1;
    @(negedge clk);
    iack = 1'b0;
    chk({tag, " R9 valid"}, {31'd0, vec_valid}, 32'd1);
    chk({tag, " R9/R10 vector"}, {24'd0, vec_out}, {24'd0, ev});
    @(negedge clk);
    chk({tag, " R9 one-cycle"}, {31'd0, vec_valid}, 32'd0);
    chk({tag, " R9 hold"}, {24'd0, vec_out}, {24'd0, ev});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hw_req = '0; abort_sw = 1'b0; reg_wr = 1'b0; reg_set = 1'b0;
    reg_addr = '0; reg_wdata = '0; iack = 1'b0;
    for (int i = 0; i < 12; i++) begin m_pend[i] = 0; m_en[i] = 0; m_lvl[i] = 0; end
    m_gen = 0; m_base = 8'h40;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq_level", {29'd0, irq_level}, 32'd0);
    chk("R1 vec_valid", {31'd0, vec_valid}, 32'd0);
    chk("R1 vec_out", {24'd0, vec_out}, 32'd0);
    for (int a = 0; a < 16; a++) rd_chk("R1 reset read", a);

    // R4: live abort bit only on index 2
    abort_sw = 1'b1;
    rd_chk("R4 abort live", 2);
    chk("R4 abort bit6", {31'd0, reg_rdata[6]}, 32'd1);
    rd_chk("R4 no live bit", 3);
    abort_sw = 1'b0;
    rd_chk("R4 abort released", 2);

    // R7/R9 sweep: each source alone at every level
    wr_reg(12, 8'h10);
    for (int i = 0; i < 12; i++) begin
      for (int l = 1; l < 8; l++) begin
        wr_reg(i, 8'h08 | 8'(l));
        if (i < 10) pulse(i); else set_sw(i);
        rd_chk("R2/R5 pending read", i);
        ack_chk("sweep");
        wr_reg(i, 8'h80);
        rd_chk("R3 clear", i);
      end
    end

    // R2: a held line does not retrigger
    wr_reg(4, 8'h0B);
    @(negedge clk); hw_req[4] = 1'b1; m_pend[4] = 1'b1;
    @(negedge clk);
    rd_chk("R2 edge set", 4);
    wr_reg(4, 8'h8B);
    @(negedge clk);
    rd_chk("R2 held high no retrigger", 4);
    hw_req[4] = 1'b0;

    // R5: software sources ignore lines and plain writes
    wr_reg(10, 8'h0F);
    pulse(10);
    rd_chk("R5 line ignored", 10);
    wr_reg(11, 8'h8F);
    rd_chk("R5 write no set", 11);
    ack_chk("R5 none active");

    // R3: bit7 of 0 leaves pending
    pulse(5); wr_reg(5, 8'h06);
    rd_chk("R3 bit7 zero keeps", 5);
    wr_reg(5, 8'h80);

    // R8: tie goes to lower index
    wr_reg(3, 8'h0D); wr_reg(7, 8'h0D);
    pulse(7); pulse(3);
    ack_chk("R8 tie");
    wr_reg(9, 8'h0F); pulse(9);
    ack_chk("R7 higher wins");

    // R6/R10: global enable off
    wr_reg(12, 8'hEF);
    rd_chk("R6 gen readback", 12);
    ack_chk("R6/R10 gated");
    wr_reg(12, 8'h10);
    rd_chk("R6 gen on", 12);
    for (int i = 0; i < 12; i++) wr_reg(i, 8'h80);
    ack_chk("R10 spurious");

    // R9: base wrap
    wr_reg(13, 8'hF8);
    rd_chk("R9 base read", 13);
    wr_reg(11, 8'h0A); set_sw(11);
    ack_chk("R9 wrap");

    // Pseudo-random sequence against the model
    for (int it = 0; it < 400; it++) begin
      rng = next_rng(rng);
      abort_sw = rng[31];
      case (rng % 5)
        0: wr_reg(int'((rng >> 4) % 12), 8'(rng >> 8));
        1: pulse(int'((rng >> 4) % 10));
        2: set_sw(10 + int'(rng[4]));
        3: wr_reg(12, (8'(rng >> 8) & 8'hEF) | ((rng[21:20] != 2'b00) ? 8'h10 : 8'h00));
        default: wr_reg(13, 8'(rng >> 8));
      endcase
      rd_chk("R4 random read", int'((rng >> 12) % 16));
      ack_chk("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule